// File: doc/BRIEF.md
# Sub-Word Split Load/Store Unit

This unit moves data between a register-sized operand and a small byte-addressed scratchpad. It can treat a single access as several narrow lanes, so low-width samples such as 4-bit or 8-bit values move in parallel. Each request carries an operation, an access size and a split count. The address is a base register plus a sign-extended immediate.

On a load, the accessed bytes are cut into equal fields. Each field is sign- or zero-extended into its own equal-width lane of the 32-bit result. On a store, the low bits of each register lane are packed side by side into the accessed bytes.

The unit accepts one request per cycle and answers every request exactly one cycle later. That short latency suits intermediate values that only need to live for one stream interval. Combinations that cannot be honoured are flagged and leave the scratchpad untouched.

Top module: `subword_lsu`

## Requirements
- R1: The byte address is `reqBase` plus the sign-extended `reqImm`, taken modulo the scratchpad size (4·2^ADDR_W bytes). Byte k of the access is the byte at address+k. Bytes are little-endian, so the lowest address lands in the least significant bits.
- R2: A request presented with `reqValid` high produces `rspValid` high on the following cycle. In every other cycle `rspValid` is low.
- R3: `reqOp` encoding is as follows:
  - 2'b00 is a signed load.
  - 2'b01 is an unsigned load.
  - 2'b10 is a store.
  - 2'b11 is not an operation and is rejected.
- R4: `reqSize` selects the access width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 is rejected. `reqSplit` holds the base-2 logarithm of the part count (parts = 1, 2, 4 or 8). From these:
  - field width = access width / parts
  - lane width = 32 / parts
- R5: A load places field i, which starts at bit i·field width of the accessed value, into lane i of `rspData`, which starts at bit i·lane width. The field is sign-extended for op 2'b00 and zero-extended for op 2'b01.
- R6: A store writes the low field-width bits of lane i of `reqStoreData` into field i of the accessed bytes. Bytes outside the access keep their contents.
- R7: A request is rejected when any of the following holds:
  - the field width is below 4 bits;
  - the size is 3 or the op is 2'b11;
  - a 16-bit access has address bit 0 set;
  - a 32-bit access has a nonzero address[1:0].

  A rejected request responds with `rspIllegal`=1 and `rspData`=0, and it changes no scratchpad byte.
- R8: A legal store responds with `rspIllegal`=0 and `rspData`=0.
- R9: A load issued in the cycle right after a store to the same bytes returns the newly stored data.
- R10: While and right after reset, `rspValid`, `rspIllegal` and `rspData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Operation code |
| reqSize | input | 2 | Access width code |
| reqSplit | input | 2 | log2 of the number of parts |
| reqBase | input | 32 | Base register value |
| reqImm | input | IMM_W | Signed immediate offset |
| reqStoreData | input | 32 | Register value to be stored |
| rspValid | output | 1 | Response present |
| rspIllegal | output | 1 | Request was rejected |
| rspData | output | 32 | Load result, lane-expanded |

## Verification
The bench first aims at lane geometry, meaning every legal mix of size and split. A swapped field or lane stride would scramble the bits across lanes, and a wrong extension would corrupt the upper lane bits on negative fields.

Sub-word stores are followed by full-word reads. A wrong byte-enable would clobber neighbouring bytes.

Rejected combinations, including field widths of 2 bits and misaligned halfwords and words, are followed by readbacks. A design that still wrote on them would show changed bytes.

Negative immediates and address wrap are also exercised, along with loads placed directly behind stores. A missed sign extension would hit the wrong word, and a late write would return stale data.

// File: rtl/subword_lsu_pkg.sv
`timescale 1ns/1ps
package subword_lsu_pkg;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_LDS = 2'b00,
    OP_LDU = 2'b01,
    OP_ST  = 2'b10,
    OP_BAD = 2'b11
  } lsuOp_e;

  typedef struct packed {
    logic       rdEn;
    logic       wrEn;
    logic       illegal;
    logic       signExt;
    logic [1:0] splitLog;
    logic [1:0] size;
    logic [1:0] byteOff;
  } lsuStrobe_t;
endpackage

// File: rtl/subword_lsu_mem.sv
`timescale 1ns/1ps
module subword_lsu_mem
  import subword_lsu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] byteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : gBank
    logic [7:0] bank [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (wrEn && byteEn[g]) bank[addr] <= wrData[g*8 +: 8];
      if (rdEn) q <= bank[addr];
    end
    assign rdData[g*8 +: 8] = q;
  end

  // R3: one port, so a request is either a read or a write
  a_r3_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rdEn && wrEn));
endmodule

// File: rtl/subword_lsu_ctrl.sv
`timescale 1ns/1ps
module subword_lsu_ctrl
  import subword_lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqSplit,
  input  logic [1:0] addrLow,
  output lsuStrobe_t reqStb,
  output lsuStrobe_t rspStb,
  output logic       rspValid
);
  lsuOp_e op;
  logic   fieldOk, aligned, legal;

  always_comb begin
    op      = lsuOp_e'(reqOp);
    fieldOk = ({1'b0, reqSize} + 3'd1) >= {1'b0, reqSplit};
    case (reqSize)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = !addrLow[0];
      default: aligned = (addrLow == 2'd0);
    endcase
    legal = (op != OP_BAD) && (reqSize != 2'd3) && fieldOk && aligned;

    reqStb.rdEn     = reqValid && legal && (op == OP_LDS || op == OP_LDU);
    reqStb.wrEn     = reqValid && legal && (op == OP_ST);
    reqStb.illegal  = reqValid && !legal;
    reqStb.signExt  = (op == OP_LDS);
    reqStb.splitLog = reqSplit;
    reqStb.size     = reqSize;
    reqStb.byteOff  = addrLow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspStb   <= '0;
    end else begin
      rspValid <= reqValid;
      rspStb   <= reqStb;
    end
  end

  a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);
  a_r3_single_action: assert property (@(posedge clk) disable iff (rst)
    $countones({reqStb.rdEn, reqStb.wrEn, reqStb.illegal}) <= 1);
endmodule

// File: rtl/subword_lsu_dp.sv
`timescale 1ns/1ps
module subword_lsu_dp
  import subword_lsu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] reqBase,
  input  logic [IMM_W-1:0]  reqImm,
  input  logic [DATA_W-1:0] reqStoreData,
  input  lsuStrobe_t        reqStb,
  input  lsuStrobe_t        rspStb,
  output logic [1:0]        addrLow,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NBYTES-1:0] memByteEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] rspData
);
  localparam int SEXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt, byteAddr, packedSt, rawLd, loadVal;

  // address generation
  always_comb begin
    immExt   = {{SEXT_W{reqImm[IMM_W-1]}}, reqImm};
    byteAddr = reqBase + immExt;
    addrLow  = byteAddr[1:0];
    memAddr  = byteAddr[ADDR_W+1:2];
    memRdEn  = reqStb.rdEn;
    memWrEn  = reqStb.wrEn;
  end

  // store packing: lane i low bits -> field i
  always_comb begin
    int fwL, lnL, acc;
    fwL = 3 + int'(reqStb.size) - int'(reqStb.splitLog);
    lnL = 5 - int'(reqStb.splitLog);
    acc = 8 << reqStb.size;
    packedSt = '0;
    for (int j = 0; j < DATA_W; j++) begin
      int fld, pos, src;
      fld = j >> fwL;
      pos = j & ((1 << fwL) - 1);
      src = (fld << lnL) + pos;
      if (j < acc) packedSt[j] = reqStoreData[src[4:0]];
    end
    memWrData = packedSt << {reqStb.byteOff, 3'b000};
    case (reqStb.size)
      2'd0:    memByteEn = 4'b0001 << reqStb.byteOff;
      2'd1:    memByteEn = 4'b0011 << reqStb.byteOff;
      default: memByteEn = 4'b1111;
    endcase
  end

  // load unpacking: field i -> lane i with extension
  always_comb begin
    int fwL, lnL, fw;
    fwL   = 3 + int'(rspStb.size) - int'(rspStb.splitLog);
    lnL   = 5 - int'(rspStb.splitLog);
    fw    = 1 << fwL;
    rawLd = memRdData >> {rspStb.byteOff, 3'b000};
    loadVal = '0;
    for (int b = 0; b < DATA_W; b++) begin
      int lane, pos, idx;
      lane = b >> lnL;
      pos  = b & ((1 << lnL) - 1);
      idx  = (lane << fwL) + ((pos < fw) ? pos : fw - 1);
      loadVal[b] = (pos < fw) ? rawLd[idx[4:0]] : (rspStb.signExt & rawLd[idx[4:0]]);
    end
    rspData = rspStb.rdEn ? loadVal : '0;
  end

  a_r7_reject_no_access: assert property (@(posedge clk) disable iff (rst)
    reqStb.illegal |-> (!memWrEn && !memRdEn));
  a_r6_enable_span: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> ($countones(memByteEn) == (1 << reqStb.size)));
  a_r5_zero_ext_byte: assert property (@(posedge clk) disable iff (rst)
    (rspStb.rdEn && !rspStb.signExt && rspStb.size == 2'd0 && rspStb.splitLog == 2'd0)
      |-> (rspData[31:8] == 24'd0));
  a_r8_store_quiet: assert property (@(posedge clk) disable iff (rst)
    rspStb.wrEn |-> (rspData == '0));
endmodule

// File: rtl/subword_lsu.sv
`timescale 1ns/1ps
module subword_lsu
  import subword_lsu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IMM_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqSize,
  input  logic [1:0]       reqSplit,
  input  logic [31:0]      reqBase,
  input  logic [IMM_W-1:0] reqImm,
  input  logic [31:0]      reqStoreData,
  output logic             rspValid,
  output logic             rspIllegal,
  output logic [31:0]      rspData
);
  lsuStrobe_t        reqStb, rspStb;
  logic [1:0]        addrLow;
  logic              memRdEn, memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [NBYTES-1:0] memByteEn;
  logic [DATA_W-1:0] memWrData, memRdData;

  subword_lsu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqSize(reqSize), .reqSplit(reqSplit), .addrLow(addrLow),
    .reqStb(reqStb), .rspStb(rspStb), .rspValid(rspValid)
  );

  subword_lsu_dp #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rst(rst), .reqBase(reqBase), .reqImm(reqImm),
    .reqStoreData(reqStoreData), .reqStb(reqStb), .rspStb(rspStb),
    .addrLow(addrLow), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memAddr(memAddr), .memByteEn(memByteEn), .memWrData(memWrData),
    .memRdData(memRdData), .rspData(rspData)
  );

  subword_lsu_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst), .rdEn(memRdEn), .wrEn(memWrEn), .addr(memAddr),
    .byteEn(memByteEn), .wrData(memWrData), .rdData(memRdData)
  );

  assign rspIllegal = rspStb.illegal;

  a_r7_reject_zero_data: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspIllegal) |-> (rspData == 32'd0));
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!rspValid && !rspIllegal && rspData == 32'd0));
endmodule

// File: tb/subword_lsu_tb.sv
`timescale 1ns/1ps
module subword_lsu_tb;
  localparam int ADDR_W = 6;
  localparam int IMM_W  = 12;
  localparam int MBYTES = 4 << ADDR_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic             reqValid;
  logic [1:0]       reqOp, reqSize, reqSplit;
  logic [31:0]      reqBase, reqStoreData;
  logic [IMM_W-1:0] reqImm;
  logic             rspValid, rspIllegal;
  logic [31:0]      rspData;

  subword_lsu #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqSize(reqSize), .reqSplit(reqSplit), .reqBase(reqBase),
    .reqImm(reqImm), .reqStoreData(reqStoreData), .rspValid(rspValid),
    .rspIllegal(rspIllegal), .rspData(rspData)
  );

  int nVec = 0, nFail = 0;
  bit [7:0] mdl [MBYTES];
  bit expValid = 0, expIll = 0;
  logic [31:0] expData = 0;
  string expTag = "R10";

  task automatic compareNow();
    nVec++;
    if (rspValid !== expValid || rspIllegal !== expIll || rspData !== expData) begin
      nFail++;
      $display("FAIL %s: got v=%0b ill=%0b data=%h, want v=%0b ill=%0b data=%h",
               expTag, rspValid, rspIllegal, rspData, expValid, expIll, expData);
    end
  endtask

  // behavioural reference; returns tag category
  task automatic predict(input bit v, input logic [1:0] op, sz, sp,
                         input logic [31:0] base, input logic [IMM_W-1:0] imm,
                         input logic [31:0] sd, input string tag);
    logic [31:0] full;
    int a, accBits, parts, fw, laneW;
    bit ok;
    longint unsigned fmask, pk, val, f, res;
    if (!v) begin
      expValid = 0; expIll = 0; expData = 0; expTag = (tag == "") ? "R2" : tag;
      return;
    end
    expValid = 1;
    full    = base + {{(32-IMM_W){imm[IMM_W-1]}}, imm};
    a       = int'(full % MBYTES);
    accBits = 8 << sz;
    parts   = 1 << sp;
    fw      = accBits / parts;
    laneW   = 32 / parts;
    ok = (op != 2'b11) && (sz != 2'd3) && (fw >= 4) && ((a % (accBits / 8)) == 0);
    if (!ok) begin
      expIll = 1; expData = 0; expTag = (tag == "") ? "R7" : tag;
      return;
    end
    expIll = 0;
    fmask = (64'd1 << fw) - 1;
    if (op == 2'b10) begin
      pk = 0;
      for (int i = 0; i < parts; i++)
        pk |= ((64'(sd) >> (i * laneW)) & fmask) << (i * fw);
      for (int k = 0; k < accBits / 8; k++) mdl[a + k] = pk[8*k +: 8];
      expData = 0;
      expTag = (tag == "") ? "R8" : tag;
    end else begin
      val = 0;
      for (int k = 0; k < accBits / 8; k++) val |= 64'(mdl[a + k]) << (8 * k);
      res = 0;
      for (int i = 0; i < parts; i++) begin
        f = (val >> (i * fw)) & fmask;
        if (op == 2'b00 && ((f >> (fw - 1)) & 1) == 1) f |= ~fmask;
        res |= (f & ((64'd1 << laneW) - 1)) << (i * laneW);
      end
      expData = res[31:0];
      expTag = (tag == "") ? "R5" : tag;
    end
  endtask

  task automatic issue(input bit v, input logic [1:0] op, sz, sp,
                       input logic [31:0] base, input logic [IMM_W-1:0] imm,
                       input logic [31:0] sd, input string tag);
    @(negedge clk);
    compareNow();
    reqValid = v; reqOp = op; reqSize = sz; reqSplit = sp;
    reqBase = base; reqImm = imm; reqStoreData = sd;
    predict(v, op, sz, sp, base, imm, sd, tag);
  endtask

  task automatic idle(input string tag);
    issue(1'b0, 2'b00, 2'd0, 2'd0, 32'd0, '0, 32'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got hang, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    rst = 1; reqValid = 0; reqOp = 0; reqSize = 0; reqSplit = 0;
    reqBase = 0; reqImm = 0; reqStoreData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); compareNow();       // R10 during reset
    rst = 0;
    @(negedge clk); compareNow();       // R10 right after reset

    // fill the scratchpad with full-word stores (R8)
    for (int w = 0; w < MBYTES / 4; w++)
      issue(1, 2'b10, 2'd2, 2'd0, w * 4, '0, 32'hA5C3_0000 ^ (w * 32'h0101_0107), "R8");

    // R9: load immediately after store
    issue(1, 2'b10, 2'd2, 2'd0, 32'h40, '0, 32'h8F3C_71E2, "R9");
    issue(1, 2'b01, 2'd2, 2'd0, 32'h40, '0, 32'h0, "R9");
    // R5: two 8-bit fields from a 16-bit access, signed and unsigned
    issue(1, 2'b00, 2'd1, 2'd1, 32'h40, '0, 0, "R5");
    issue(1, 2'b01, 2'd1, 2'd1, 32'h42, '0, 0, "R5");
    // R4: eight 4-bit fields from a word, signed
    issue(1, 2'b00, 2'd2, 2'd3, 32'h40, '0, 0, "R4");
    // R6: 4-bit lanes into halfword at 0x22, then read whole word
    issue(1, 2'b10, 2'd1, 2'd2, 32'h22, '0, 32'h1A2B_3C4D, "R6");
    issue(1, 2'b01, 2'd2, 2'd0, 32'h20, '0, 0, "R6");
    issue(1, 2'b10, 2'd0, 2'd1, 32'h25, '0, 32'h0009_0006, "R6");
    issue(1, 2'b01, 2'd2, 2'd0, 32'h24, '0, 0, "R6");
    // R7: rejected requests, then readbacks show no change
    issue(1, 2'b10, 2'd0, 2'd2, 32'h48, '0, 32'hFFFF_FFFF, "R7");
    issue(1, 2'b10, 2'd1, 2'd0, 32'h49, '0, 32'hFFFF_FFFF, "R7");
    issue(1, 2'b10, 2'd2, 2'd0, 32'h4A, '0, 32'hFFFF_FFFF, "R7");
    issue(1, 2'b10, 2'd3, 2'd0, 32'h48, '0, 32'hFFFF_FFFF, "R7");
    issue(1, 2'b01, 2'd2, 2'd0, 32'h48, '0, 0, "R7");
    // R3: op 2'b11 rejected
    issue(1, 2'b11, 2'd2, 2'd0, 32'h48, '0, 0, "R3");
    // R1: negative immediate and wraparound
    issue(1, 2'b01, 2'd2, 2'd0, 32'h1000_0010, 12'hFFC, 0, "R1");
    issue(1, 2'b00, 2'd0, 2'd0, 32'hFC, 12'd9, 0, "R1");
    idle("R2");
    idle("R2");

    for (int n = 0; n < 4000; n++) begin
      bit v;
      v = ($urandom % 8) != 0;
      issue(v, 2'($urandom), 2'($urandom % 3 + (($urandom % 16) == 0 ? 1 : 0)),
            2'($urandom), $urandom, IMM_W'($urandom), $urandom, "");
    end
    idle("R2");
    idle("R2");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule